// File: doc/BRIEF.md
# Calibrate-and-Hold Oscillator Control Sequencer

This block is the digital controller beside a self-calibrating on-chip oscillator. After a start request it walks through three ordered phases. In calibration it enables the reference path and the analog feedback loop, then counts reference-clock cycles so the loop can settle. In conversion it first gives the DAC a one-cycle discharge pulse. It then runs a successive-approximation search over the DAC code, most significant bit first, steered by an external comparator. In retention it freezes the resolved code in a holding register that keeps driving the DAC, and it raises `done`.

`done` serves as the select of the analog mux that moves the oscillator control from the loop amplifier to the DAC. When `done` is high, every enable output is low, so the converter, the reference path and the loop are powered down and the reference clock may stop. The held code stays in place until reset or a new start request, which reruns the whole sequence from calibration.

Every enable is a flop output. Each one therefore changes only on the clock edge that ends a phase.

Top module: `cal_hold_seq`

## Requirements
- R1: After reset, and until a start request is sampled, `dac_code` is 0 and `done`, `adc_en`, `ref_en`, `loop_en` and `dac_dischg` are all 0.
- R2: A `start` sampled high while the block is idle or in retention begins calibration on the next cycle. In calibration `ref_en` and `loop_en` are 1, `adc_en` is 0, `done` is 0 and `dac_code` is 0.
- R3: Calibration lasts exactly `SETTLE_CYCLES` reference cycles (default 2000). Conversion begins on the cycle after the last one.
- R4: The first conversion cycle is a discharge cycle. In that cycle `dac_dischg` is 1, `adc_en` is 1 and `dac_code` is 0. `dac_dischg` is 0 in every other cycle.
- R5: The next `CODE_W` cycles (default 10) are trials. The first trial code is half scale, with only the MSB set. At the end of each trial cycle `cmp_hi` is sampled. A value of 1 means the DAC voltage is above the input, and the trial bit is cleared. A value of 0 keeps the bit. The next lower bit is then set for the following trial.
- R6: On the cycle after the LSB trial, `done` becomes 1 and `dac_code` shows the resolved code. For an ideal comparator this is the input level in LSBs. `adc_en`, `ref_en` and `loop_en` become 0 at the same edge.
- R7: In retention, `dac_code` and `done` stay constant for any `cmp_hi` activity and for any length of time.
- R8: A `start` sampled during calibration or conversion is ignored. The sequence timing and the result are unchanged.
- R9: `done` is 0 throughout calibration and conversion. It rises only at the end of conversion.
- R10: Asserting `rst_n` low at any point returns the block to the R1 state at once and clears the held code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the calibrate/convert/hold sequence |
| cmp_hi | input | 1 | Comparator: 1 when the DAC voltage is above the analog input |
| dac_code | output | CODE_W | Code driving the DAC: trial code, or held code in retention |
| done | output | 1 | High in retention only; analog mux select to the DAC path |
| adc_en | output | 1 | Converter enable (discharge and trial cycles) |
| ref_en | output | 1 | Reference path enable (calibration and conversion) |
| loop_en | output | 1 | Feedback loop enable (calibration and conversion) |
| dac_dischg | output | 1 | One-cycle DAC discharge pulse before the trials |

## Verification
The hardest situations to reach are a start request that arrives while calibration or conversion is already running, and comparator activity after the code has been frozen. Neither one shows up in a plain run. The bench drives the comparator as an ideal model of a chosen input level, so every run has a known final code. In some runs it pulses `start` at random points during calibration and conversion. In retention it changes the modelled input level, which makes `cmp_hi` toggle. A reset in the middle of a conversion covers the abort path.

// File: rtl/cal_hold_pkg.sv
package cal_hold_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CAL  = 3'd1,
        PH_CLR  = 3'd2,
        PH_CONV = 3'd3,
        PH_HOLD = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   done;
        logic   adc_en;
        logic   ref_en;
        logic   loop_en;
        logic   dischg;
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{phase: PH_IDLE, default: 1'b0};

endpackage

// File: rtl/chs_settle_timer.sv
module chs_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic term
);
    localparam int unsigned CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        term  = run && (cnt_q == LAST);
        cnt_d = '0;
        if (run && !term) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/chs_sar_search.sv
module chs_sar_search #(
    parameter int unsigned CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              cmp_hi,
    output logic [CODE_W-1:0] trial,
    output logic              last,
    output logic [CODE_W-1:0] result
);
    localparam int unsigned IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [CODE_W-1:0] HALF = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [IDX_W-1:0]  TOP  = IDX_W'(CODE_W - 1);

    logic [CODE_W-1:0] trial_d, trial_q;
    logic [IDX_W-1:0]  idx_d, idx_q;
    logic [CODE_W-1:0] resolved;

    always_comb begin
        resolved = trial_q;
        if (cmp_hi) begin
            resolved[idx_q] = 1'b0;
        end
        last    = (idx_q == '0);
        trial_d = '0;
        idx_d   = '0;
        if (load) begin
            trial_d = HALF;
            idx_d   = TOP;
        end else if (step && !last) begin
            trial_d              = resolved;
            trial_d[idx_q - 1'b1] = 1'b1;
            idx_d                = idx_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q <= '0;
            idx_q   <= '0;
        end else begin
            trial_q <= trial_d;
            idx_q   <= idx_d;
        end
    end

    assign trial  = trial_q;
    assign result = resolved;
endmodule

// File: rtl/chs_hold_bank.sv
module chs_hold_bank #(
    parameter int unsigned CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [CODE_W-1:0] d,
    output logic [CODE_W-1:0] q
);
    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        logic bit_d, bit_q;

        always_comb begin
            bit_d = bit_q;
            if (clr) begin
                bit_d = 1'b0;
            end else if (load) begin
                bit_d = d[b];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= bit_d;
            end
        end

        assign q[b] = bit_q;
    end
endmodule

// File: rtl/cal_hold_seq.sv
module cal_hold_seq
    import cal_hold_pkg::*;
#(
    parameter int unsigned CODE_W        = 10,
    parameter int unsigned SETTLE_CYCLES = 2000
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmp_hi,
    output logic [CODE_W-1:0] dac_code,
    output logic              done,
    output logic              adc_en,
    output logic              ref_en,
    output logic              loop_en,
    output logic              dac_dischg
);
    seq_state_t st_d, st_q;

    logic              start_ok;
    logic              settle_run, settle_term;
    logic              sar_load, sar_step, sar_last;
    logic [CODE_W-1:0] sar_trial, sar_result;
    logic              hold_load;
    logic [CODE_W-1:0] hold_code;

    chs_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk  (clk_ref),
        .rst_n(rst_n),
        .run  (settle_run),
        .term (settle_term)
    );

    chs_sar_search #(.CODE_W(CODE_W)) u_sar (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .load  (sar_load),
        .step  (sar_step),
        .cmp_hi(cmp_hi),
        .trial (sar_trial),
        .last  (sar_last),
        .result(sar_result)
    );

    chs_hold_bank #(.CODE_W(CODE_W)) u_hold (
        .clk  (clk_ref),
        .rst_n(rst_n),
        .clr  (start_ok),
        .load (hold_load),
        .d    (sar_result),
        .q    (hold_code)
    );

    always_comb begin
        start_ok   = start && (st_q.phase == PH_IDLE || st_q.phase == PH_HOLD);
        settle_run = (st_q.phase == PH_CAL);
        sar_load   = (st_q.phase == PH_CLR);
        sar_step   = (st_q.phase == PH_CONV);
        hold_load  = sar_step && sar_last;

        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: if (start_ok)    st_d.phase = PH_CAL;
            PH_CAL:  if (settle_term) st_d.phase = PH_CLR;
            PH_CLR:                   st_d.phase = PH_CONV;
            PH_CONV: if (sar_last)    st_d.phase = PH_HOLD;
            PH_HOLD: if (start_ok)    st_d.phase = PH_CAL;
            default:                  st_d.phase = PH_IDLE;
        endcase

        st_d.done    = (st_d.phase == PH_HOLD);
        st_d.adc_en  = (st_d.phase == PH_CLR) || (st_d.phase == PH_CONV);
        st_d.ref_en  = (st_d.phase == PH_CAL) || st_d.adc_en;
        st_d.loop_en = (st_d.phase == PH_CAL) || st_d.adc_en;
        st_d.dischg  = (st_d.phase == PH_CLR);
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code   = st_q.done ? hold_code : sar_trial;
    assign done       = st_q.done;
    assign adc_en     = st_q.adc_en;
    assign ref_en     = st_q.ref_en;
    assign loop_en    = st_q.loop_en;
    assign dac_dischg = st_q.dischg;
endmodule

// File: rtl/chs_checker.sv
module chs_checker #(
    parameter int unsigned CODE_W        = 10,
    parameter int unsigned SETTLE_CYCLES = 2000
) (
    input logic              clk_ref,
    input logic              rst_n,
    input logic              start,
    input logic              cmp_hi,
    input logic [CODE_W-1:0] dac_code,
    input logic              done,
    input logic              adc_en,
    input logic              ref_en,
    input logic              loop_en,
    input logic              dac_dischg
);
    localparam int unsigned CW = $clog2(SETTLE_CYCLES + CODE_W + 4) + 1;
    localparam logic [CODE_W-1:0] HALF = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CW-1:0] cal_cnt_q, conv_cnt_q;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            cal_cnt_q  <= '0;
            conv_cnt_q <= '0;
        end else begin
            if (!ref_en)              cal_cnt_q <= '0;
            else if (!adc_en)         cal_cnt_q <= cal_cnt_q + 1'b1;
            if (adc_en)               conv_cnt_q <= conv_cnt_q + 1'b1;
            else                      conv_cnt_q <= '0;
        end
    end

    p_settle_len_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(adc_en) |-> (cal_cnt_q == CW'(SETTLE_CYCLES)));

    p_dischg_first_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        dac_dischg |-> (adc_en && dac_code == '0));

    p_half_scale_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        dac_dischg |=> (!dac_dischg && adc_en && dac_code == HALF));

    p_conv_len_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(done) |-> (conv_cnt_q == CW'(CODE_W + 1)));

    p_gates_off_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        done |-> (!adc_en && !ref_en && !loop_en && !dac_dischg));

    p_hold_stable_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(dac_code));

    p_done_after_conv_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(done) |-> $past(adc_en));
endmodule

bind cal_hold_seq chs_checker #(
    .CODE_W       (CODE_W),
    .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chs_checker (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .start     (start),
    .cmp_hi    (cmp_hi),
    .dac_code  (dac_code),
    .done      (done),
    .adc_en    (adc_en),
    .ref_en    (ref_en),
    .loop_en   (loop_en),
    .dac_dischg(dac_dischg)
);

// File: tb/tb_cal_hold_seq.sv
module tb_cal_hold_seq;
    localparam int W = 10;
    localparam int S = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_i = 1'b0;
    logic [W-1:0] dac_code;
    logic         done, adc_en, ref_en, loop_en, dac_dischg;

    always #5 clk = ~clk;

    cal_hold_seq #(.CODE_W(W), .SETTLE_CYCLES(S)) dut (
        .clk_ref(clk), .rst_n(rst_n), .start(start_i), .cmp_hi(cmp_i),
        .dac_code(dac_code), .done(done), .adc_en(adc_en), .ref_en(ref_en),
        .loop_en(loop_en), .dac_dischg(dac_dischg)
    );

    int    n_cmp = 0, n_bad = 0;
    int    m_ph = 0, m_cnt = 0, m_bit = 0, m_hold = 0, vin = 0;
    bit    first_reset = 1'b1;
    string m_tag = "R1";

    // behavioural model: 0 idle, 1 settle, 2 discharge, 3 trials, 4 hold
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_bit = 0; m_hold = 0;
            m_tag = first_reset ? "R1" : "R10";
        end else begin
            case (m_ph)
                0: if (start_i) begin m_ph = 1; m_cnt = 0; m_tag = "R2"; end
                   else m_tag = first_reset ? "R1" : "R10";
                1: begin
                    if (m_cnt == S - 1) begin m_ph = 2; m_tag = "R4"; end
                    else begin m_cnt++; m_tag = "R3"; end
                    if (start_i) m_tag = "R8";
                end
                2: begin m_ph = 3; m_bit = W - 1; m_tag = start_i ? "R8" : "R5"; end
                3: begin
                    if (m_bit == 0) begin m_ph = 4; m_hold = vin; m_tag = "R6"; end
                    else begin m_bit--; m_tag = "R5"; end
                    if (start_i) m_tag = "R8";
                end
                default: if (start_i) begin m_ph = 1; m_cnt = 0; m_tag = "R2"; end
                         else m_tag = "R7";
            endcase
        end
    end

    function automatic int exp_code();
        if (m_ph == 4) return m_hold;
        if (m_ph == 3) return ((vin >> (m_bit + 1)) << (m_bit + 1)) | (1 << m_bit);
        return 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string dtag;
        dtag = (m_ph >= 1 && m_ph <= 3) ? "R9" : m_tag;
        chk(m_tag, "dac_code", int'(dac_code), exp_code());
        chk(dtag, "done", int'(done), int'(m_ph == 4));
        chk(m_tag, "adc_en", int'(adc_en), int'(m_ph == 2 || m_ph == 3));
        chk(m_tag, "ref_en", int'(ref_en), int'(m_ph >= 1 && m_ph <= 3));
        chk(m_tag, "loop_en", int'(loop_en), int'(m_ph >= 1 && m_ph <= 3));
        chk(m_tag, "dac_dischg", int'(dac_dischg), int'(m_ph == 2));
    endtask

    task automatic step(bit st);
        @(negedge clk);
        compare_all();
        start_i = st;
        cmp_i   = (int'(dac_code) > vin);
    endtask

    task automatic run(int v, bit mid);
        vin = v;
        step(1'b1);
        for (int i = 0; i < S + W + 2; i++) begin
            step(mid && m_ph >= 1 && m_ph <= 3 && $urandom_range(0, 3) == 0);
        end
        for (int i = 0; i < 4; i++) begin
            vin = $urandom_range(0, (1 << W) - 1);   // R7: comparator noise in hold
            step(1'b0);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog: got 0 expected 1");
        summary();
    end

    initial begin
        repeat (3) step(1'b0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) step(1'b0);
        first_reset = 1'b0;
        foreach (corner_vals[k]) run(corner_vals[k], 1'b0);
        for (int r = 0; r < 30; r++) run($urandom_range(0, (1 << W) - 1), 1'b1);
        // R10: abort in the middle of conversion
        vin = 777;
        step(1'b1);
        for (int i = 0; i < S + 5; i++) step(1'b0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) step(1'b0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) step(1'b0);
        run(300, 1'b0);
        // R10: reset while holding
        @(negedge clk); rst_n = 1'b0;
        repeat (2) step(1'b0);
        @(negedge clk); rst_n = 1'b1;
        run(1023, 1'b1);
        repeat (3) step(1'b0);
        summary();
    end

    int corner_vals[7] = '{0, 1023, 512, 511, 1, 682, 341};
endmodule